// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the processor side of a narrow external bus on which the low address byte and the data byte share one set of eight lines. A request names one of five machine cycles (opcode fetch, memory read, memory write, I/O read, I/O write) and supplies a 16-bit address and a write byte. The sequencer then steps through T-states, one per clock. In each T-state it drives the dedicated high address lines, the shared lines, an address-latch strobe, a memory/I-O select with a two-bit status code, and active-low read and write strobes.

During the first T-state the low address byte sits on the shared lines while the latch strobe is high, so an external transparent latch can hold it for the rest of the cycle. The strobes follow once the address phase is over. For reads, the sequencer releases the shared lines and captures the byte returned by the memory or port. For writes, it drives the write byte on those lines. An opcode fetch runs one idle T-state longer than the other cycles. A single-clock done pulse marks the end of every cycle and comes with the captured byte. The shared lines are brought out as separate output, output-enable and input signals, which the pad ring combines.

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset and whenever no cycle is running, busy and done are 0, ale is 0, rd_n and wr_n are 1, mux_oe is 0 and the status outputs {io_m,s1,s0} are 000.
- R2: ale is 1 in the first T-state of every cycle and 0 in every other clock. In that T-state mux_oe is 1 and mux_out carries the low address byte, so a latch that is transparent while ale is high still holds that byte in the second T-state.
- R3: The status {io_m,s1,s0} equals 011 for an opcode fetch (req_kind 0), 010 for a memory read (1), 001 for a memory write (2), 110 for an I/O read (3) and 101 for an I/O write (4). It is held unchanged through every T-state of the cycle.
- R4: For the three read kinds (0, 1, 3), rd_n is 0 in T-states 2 and 3 and mux_oe is 0 there. The byte present on mux_in in T-state 3 is the one returned on rdata; a byte present only in T-state 2 is not.
- R5: For the two write kinds (2, 4), wr_n is 0 in T-states 2 and 3, and in both mux_oe is 1 with mux_out equal to req_wdata. rd_n stays 1 throughout.
- R6: An opcode fetch lasts four T-states and every other kind lasts three. busy is 1 for exactly those clocks. done is 1 for the single clock after the last T-state, with busy 0 and, for reads, rdata valid. In the fourth T-state of an opcode fetch both strobes are 1, mux_oe is 0 and addr_hi is 00h.
- R7: addr_hi carries req_addr[15:8] for memory kinds during T-states 1 to 3, and is 00h outside those T-states.
- R8: I/O kinds present req_addr[7:0] as the port number on both addr_hi and mux_out in T-state 1.
- R9: A request raised while a cycle is running is ignored, and so is a req_kind value of 5, 6 or 7. Neither starts a cycle or changes the running cycle's status.
- R10: rd_n and wr_n are never 0 in the same clock, and ale is never 1 while a strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request a machine cycle (taken only when idle) |
| req_kind | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| req_addr | input | 16 | Cycle address; bits 7:0 are the port number for I/O |
| req_wdata | input | 8 | Byte driven in write cycles |
| busy | output | 1 | A machine cycle is in progress |
| done | output | 1 | One-clock pulse after the last T-state |
| rdata | output | 8 | Byte captured in the last read T-state |
| addr_hi | output | 8 | Dedicated high address lines |
| mux_out | output | 8 | Value driven on the shared address/data lines |
| mux_oe | output | 1 | Output enable of the shared lines |
| mux_in | input | 8 | Value sensed on the shared lines |
| ale | output | 1 | Address latch strobe, high in T-state 1 |
| io_m | output | 1 | 1 for I/O cycles, 0 for memory cycles |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The bench swaps the byte on the shared lines between the second and the third T-state. A sequencer that captures one T-state early therefore returns the complement of the expected byte. It checks the extra fourth T-state of an opcode fetch: a design that ends the fetch after three T-states pulses done one clock early, and one that keeps reading in the fourth T-state leaves rd_n low there. A second request injected mid-cycle, and the unused kind codes raised while idle, would show up as a changed status code or a spurious extra cycle. Checking the external latch output and the decoded memory/I-O strobes exposes a low address byte that is not held through ale, and an I/O cycle that leaves the port number off the high byte.

// File: rtl/mbs_pkg.sv
`timescale 1ns/1ps
package mbs_pkg;

   typedef enum logic [2:0] {
      CYC_FETCH = 3'd0,
      CYC_MRD   = 3'd1,
      CYC_MWR   = 3'd2,
      CYC_IORD  = 3'd3,
      CYC_IOWR  = 3'd4
   } cyc_kind_e;

   typedef struct packed {
      logic io_m;
      logic s1;
      logic s0;
   } bus_status_t;

   localparam bus_status_t ST_IDLE = '0;

   function automatic logic kind_known(input logic [2:0] k);
      return (k <= 3'd4);
   endfunction

   function automatic bus_status_t status_for(input cyc_kind_e k);
      bus_status_t st;
      case (k)
         CYC_FETCH: st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
         CYC_MRD:   st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
         CYC_MWR:   st = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
         CYC_IORD:  st = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
         CYC_IOWR:  st = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
         default:   st = ST_IDLE;
      endcase
      return st;
   endfunction

endpackage

// File: rtl/mbs_cycle_decode.sv
`timescale 1ns/1ps
module mbs_cycle_decode
   import mbs_pkg::*;
#(
   parameter int TW      = 3,
   parameter int OPF_LEN = 4,
   parameter int RW_LEN  = 3
) (
   input  cyc_kind_e        kind,
   output bus_status_t      status,
   output logic             is_read,
   output logic             is_write,
   output logic             is_io,
   output logic [TW-1:0]    last_t
);

   localparam logic [TW-1:0] T_OPF = TW'(OPF_LEN);
   localparam logic [TW-1:0] T_RW  = TW'(RW_LEN);

   always_comb begin
      status   = status_for(kind);
      is_read  = (kind == CYC_FETCH) || (kind == CYC_MRD) || (kind == CYC_IORD);
      is_write = (kind == CYC_MWR) || (kind == CYC_IOWR);
      is_io    = (kind == CYC_IORD) || (kind == CYC_IOWR);
      last_t   = (kind == CYC_FETCH) ? T_OPF : T_RW;
   end

endmodule

// File: rtl/mbs_tstate_seq.sv
`timescale 1ns/1ps
module mbs_tstate_seq #(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [TW-1:0] last_t,
   output logic [TW-1:0] tstate,
   output logic          busy,
   output logic          done
);

   localparam logic [TW-1:0] T_IDLE = '0;
   localparam logic [TW-1:0] T_ONE  = TW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tstate <= T_IDLE;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tstate == T_IDLE) begin
            if (start) tstate <= T_ONE;
         end else if (tstate == last_t) begin
            tstate <= T_IDLE;
            done   <= 1'b1;
         end else begin
            tstate <= tstate + T_ONE;
         end
      end
   end

   assign busy = (tstate != T_IDLE);

   // R6: done is a single-clock pulse
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done held longer than one clock");

   // R6: done only follows a running cycle
   a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy))
      else $error("done without a preceding cycle");

endmodule

// File: rtl/mbs_bus_drive.sv
`timescale 1ns/1ps
module mbs_bus_drive #(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 8,
   parameter int TW             = 3,
   parameter int RW_LEN         = 3,
   parameter int HOLD_LEN       = 3,
   parameter bit IO_ADDR_MIRROR = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 busy,
   input  logic [TW-1:0]        tstate,
   input  logic                 is_read,
   input  logic                 is_write,
   input  logic                 is_io,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0]    mux_out,
   output logic                 mux_oe,
   output logic                 ale,
   output logic                 rd_n,
   output logic                 wr_n,
   output logic                 capture
);

   localparam int AHI_W = ADDR_W - DATA_W;
   localparam logic [TW-1:0] T_ONE  = TW'(1);
   localparam logic [TW-1:0] T_TWO  = TW'(2);
   localparam logic [TW-1:0] T_RW   = TW'(RW_LEN);
   localparam logic [TW-1:0] T_HOLD = TW'(HOLD_LEN);

   logic [AHI_W-1:0] io_hi;
   logic [AHI_W-1:0] hi_sel;
   logic             addr_phase;
   logic             strobe_phase;
   logic             hi_phase;

   generate
      if (IO_ADDR_MIRROR) begin : g_io_mirror
         assign io_hi = AHI_W'(addr[DATA_W-1:0]);
      end else begin : g_io_zero
         assign io_hi = '0;
      end
   endgenerate

   always_comb begin
      addr_phase   = busy && (tstate == T_ONE);
      strobe_phase = busy && (tstate >= T_TWO) && (tstate <= T_RW);
      hi_phase     = busy && (tstate <= T_HOLD);
      hi_sel       = is_io ? io_hi : addr[ADDR_W-1:DATA_W];

      addr_hi = hi_phase ? hi_sel : '0;
      ale     = addr_phase;
      mux_oe  = addr_phase || (is_write && strobe_phase);
      mux_out = addr_phase ? addr[DATA_W-1:0] : wdata;
      rd_n    = !(is_read && strobe_phase);
      wr_n    = !(is_write && strobe_phase);
      capture = is_read && busy && (tstate == T_RW);
   end

   // R10: the two strobes are exclusive
   a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n))
      else $error("read and write strobes both active");

   // R10: ale never overlaps a strobe
   a_r10_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n))
      else $error("ale during a strobe");

   // R4: shared lines released while reading
   a_r4_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !mux_oe)
      else $error("shared lines driven during read");

   // R2: ale always comes with a driven address
   a_r2_ale_drives_lines: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> mux_oe)
      else $error("ale with lines released");

endmodule

// File: rtl/mux_bus_sequencer.sv
`timescale 1ns/1ps
module mux_bus_sequencer
   import mbs_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 8,
   parameter int OPF_LEN        = 4,
   parameter int RW_LEN         = 3,
   parameter int HOLD_LEN       = 3,
   parameter bit IO_ADDR_MIRROR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [2:0]               req_kind,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     busy,
   output logic                     done,
   output logic [DATA_W-1:0]        rdata,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0]        mux_out,
   output logic                     mux_oe,
   input  logic [DATA_W-1:0]        mux_in,
   output logic                     ale,
   output logic                     io_m,
   output logic                     s1,
   output logic                     s0,
   output logic                     rd_n,
   output logic                     wr_n
);

   localparam int TW = $clog2(OPF_LEN + 1);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("address must be twice the data width");
      end
      if (RW_LEN < 3) begin : g_bad_rw
         $error("read/write cycles need at least three T-states");
      end
      if (OPF_LEN < RW_LEN) begin : g_bad_opf
         $error("fetch may not be shorter than a read");
      end
      if (HOLD_LEN < 1 || HOLD_LEN > OPF_LEN) begin : g_bad_hold
         $error("high address hold out of range");
      end
   endgenerate

   cyc_kind_e            kind_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [DATA_W-1:0]    wdata_q;
   logic                 start;
   logic [TW-1:0]        tstate;
   logic [TW-1:0]        last_t;
   bus_status_t          dec_status;
   bus_status_t          out_status;
   logic                 is_read, is_write, is_io, capture;

   assign start = req_valid && !busy && kind_known(req_kind);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= CYC_FETCH;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start) begin
         kind_q  <= cyc_kind_e'(req_kind);
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata <= '0;
      else if (capture) rdata <= mux_in;
   end

   mbs_cycle_decode #(
      .TW(TW), .OPF_LEN(OPF_LEN), .RW_LEN(RW_LEN)
   ) u_dec (
      .kind(kind_q), .status(dec_status), .is_read(is_read),
      .is_write(is_write), .is_io(is_io), .last_t(last_t)
   );

   mbs_tstate_seq #(.TW(TW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .last_t(last_t),
      .tstate(tstate), .busy(busy), .done(done)
   );

   mbs_bus_drive #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TW(TW), .RW_LEN(RW_LEN),
      .HOLD_LEN(HOLD_LEN), .IO_ADDR_MIRROR(IO_ADDR_MIRROR)
   ) u_drv (
      .clk(clk), .rst_n(rst_n), .busy(busy), .tstate(tstate),
      .is_read(is_read), .is_write(is_write), .is_io(is_io),
      .addr(addr_q), .wdata(wdata_q), .addr_hi(addr_hi),
      .mux_out(mux_out), .mux_oe(mux_oe), .ale(ale),
      .rd_n(rd_n), .wr_n(wr_n), .capture(capture)
   );

   assign out_status = busy ? dec_status : ST_IDLE;
   assign io_m = out_status.io_m;
   assign s1   = out_status.s1;
   assign s0   = out_status.s0;

   // R3, R9: status pins hold for the whole cycle
   a_r3_status_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable({io_m, s1, s0}))
      else $error("status changed mid-cycle");

   // R9: the captured request does not change while running
   a_r9_request_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(addr_q) && $stable(kind_q)))
      else $error("request changed mid-cycle");

   // R1: idle bus is quiet
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ale && rd_n && wr_n && !mux_oe && {io_m, s1, s0} == 3'b000))
      else $error("bus active while idle");

endmodule

// File: tb/sim_mux_bus_sequencer.sv
`timescale 1ns/1ps
module sim_mux_bus_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic        busy, done, ale, io_m, s1, s0, rd_n, wr_n, mux_oe;
   logic [7:0]  rdata, addr_hi, mux_out, mux_in;
   logic [7:0]  mem_byte = 8'h00;
   logic [7:0]  lat_lo = 8'h00;
   logic        memr_n, memw_n, ior_n, iow_n;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   mux_bus_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .rdata(rdata), .addr_hi(addr_hi), .mux_out(mux_out), .mux_oe(mux_oe),
      .mux_in(mux_in), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0),
      .rd_n(rd_n), .wr_n(wr_n)
   );

   // shared-line model: memory drives while read strobe is low
   assign mux_in = !rd_n ? mem_byte : (mux_oe ? mux_out : 8'h00);

   // external transparent address latch
   always @* if (ale) lat_lo = mux_out;

   // external control decode
   assign memr_n = rd_n | io_m;
   assign memw_n = wr_n | io_m;
   assign ior_n  = rd_n | ~io_m;
   assign iow_n  = wr_n | ~io_m;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      chk(!busy && !done, {tag, " R1 busy/done"}, {busy, done}, 0);
      chk(!ale && rd_n && wr_n && !mux_oe, {tag, " R1 strobes"},
          {ale, rd_n, wr_n, mux_oe}, 4'b0110);
      chk({io_m, s1, s0} == 3'b000, {tag, " R1 status"}, {io_m, s1, s0}, 0);
   endtask

   task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] rb);
      logic rd, wr, io;
      int   len;
      logic [7:0] hi, lo;
      logic [2:0] st;
      rd  = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
      wr  = (k == 3'd2) || (k == 3'd4);
      io  = (k == 3'd3) || (k == 3'd4);
      len = (k == 3'd0) ? 4 : 3;
      lo  = a[7:0];
      hi  = io ? a[7:0] : a[15:8];
      case (k)
         3'd0: st = 3'b011;
         3'd1: st = 3'b010;
         3'd2: st = 3'b001;
         3'd3: st = 3'b110;
         default: st = 3'b101;
      endcase
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
      mem_byte = ~rb;
      for (int t = 1; t <= len; t++) begin
         @(negedge clk);
         req_valid = 1'b0;
         chk(busy, "R6 busy in cycle", busy, 1);
         chk(ale == (t == 1), "R2 ale timing", ale, (t == 1));
         chk({io_m, s1, s0} == st, "R3 status code", {io_m, s1, s0}, st);
         chk(addr_hi == ((t <= 3) ? hi : 8'h00), "R7/R8 high address",
             addr_hi, (t <= 3) ? hi : 8'h00);
         if (t == 1) begin
            chk(mux_oe && mux_out == lo, "R2/R8 low address on lines",
                {mux_oe, mux_out}, {1'b1, lo});
         end
         if (t == 2) begin
            chk(lat_lo == lo, "R2 latched low address", lat_lo, lo);
         end
         if (t == 2 || t == 3) begin
            chk(rd_n == !rd, "R4 read strobe", rd_n, !rd);
            chk(wr_n == !wr, "R5 write strobe", wr_n, !wr);
            if (rd) chk(!mux_oe, "R4 lines released", mux_oe, 0);
            if (wr) chk(mux_oe && mux_out == wd, "R5 write data",
                        {mux_oe, mux_out}, {1'b1, wd});
            chk({memr_n, memw_n, ior_n, iow_n} ==
                {!(rd && !io), !(wr && !io), !(rd && io), !(wr && io)},
                "R3 decoded strobes", {memr_n, memw_n, ior_n, iow_n},
                {!(rd && !io), !(wr && !io), !(rd && io), !(wr && io)});
            if (t == 3) mem_byte = rb;
         end
         if (t == 4) begin
            chk(rd_n && wr_n && !mux_oe, "R6 fetch T4 idle bus",
                {rd_n, wr_n, mux_oe}, 3'b110);
         end
      end
      @(negedge clk);
      chk(done && !busy, "R6 done pulse", {done, busy}, 2'b10);
      if (rd) chk(rdata == rb, "R4 captured byte", rdata, rb);
      @(negedge clk);
      chk(!done, "R6 done single", done, 0);
   endtask

   task automatic test_busy_ignore();
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h4321;
      @(negedge clk);
      req_kind = 3'd4; req_addr = 16'h00EE;  // still raised during T1..T3
      for (int t = 2; t <= 3; t++) begin
         @(negedge clk);
         chk({io_m, s1, s0} == 3'b010, "R9 status unchanged by busy req",
             {io_m, s1, s0}, 3'b010);
         chk(addr_hi == 8'h43, "R9 address unchanged", addr_hi, 8'h43);
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk(done, "R9 original cycle completes", done, 1);
      @(negedge clk);
      check_idle("R9 no extra cycle");
   endtask

   task automatic test_bad_kinds();
      for (int k = 5; k <= 7; k++) begin
         @(negedge clk);
         req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'hBEEF;
         @(negedge clk);
         req_valid = 1'b0;
         check_idle("R9 unknown kind");
         chk(!ale, "R9 no ale for unknown kind", ale, 0);
      end
   endtask

   initial begin
      #(200000 * 4);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("after reset");
      run_cycle(3'd0, 16'h2005, 8'h00, 8'h4F);
      run_cycle(3'd1, 16'h2001, 8'h00, 8'h32);
      run_cycle(3'd2, 16'h1234, 8'hA5, 8'h00);
      run_cycle(3'd3, 16'hAB7C, 8'h00, 8'h5A);
      run_cycle(3'd4, 16'h00E1, 8'h3C, 8'h00);
      run_cycle(3'd1, 16'hFFFF, 8'h00, 8'hFF);
      run_cycle(3'd0, 16'h0000, 8'h00, 8'h00);
      run_cycle(3'd2, 16'h8001, 8'h00, 8'h00);
      test_busy_ignore();
      test_bad_kinds();
      run_cycle(3'd0, 16'hC3A9, 8'h00, 8'h96);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule